// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external asynchronous static RAM of 512K bytes. The host issues one transfer at a time over a request/ready handshake that carries a write flag, a 19-bit address and a write byte. A read returns its byte on `rdata` together with a one-cycle `rvalid` strobe. On the memory side the block drives active-low chip select, output enable and write strobe, a registered address bus, and a data bus split into an outgoing byte, an incoming byte and a drive enable for the pad buffer.

Every memory strobe comes straight from a flip-flop. The length of each phase comes from a clock-period parameter and a set of nanosecond minimums, each rounded up to whole cycles with a floor of one cycle. A read holds the output enable low until both the address-to-data time and the enable-to-data time have passed, and then samples. A guard phase follows every read so that the memory releases the bus before the controller can drive it. Writes are strobe-controlled: the output enable stays high for the whole write, and the address and data are held from acceptance until after the strobe returns high.

Top module: `asram_ctrl`

## Requirements
- R1: During reset and right after it, `ready`=1, `rvalid`=0, `mem_ce_n`=`mem_oe_n`=`mem_we_n`=1 and `mem_dq_oe`=0.
- R2: A read holds `mem_ce_n`=0 and `mem_oe_n`=0 with `mem_we_n`=1 for exactly RD cycles, where RD = ceil(max(12 ns, 12 ns, 6 ns)/period) with a minimum of 1 (2 at a 10 ns period). `mem_we_n` is never low while `mem_oe_n` is low.
- R3: Each read gives exactly one `rvalid` pulse, one cycle long. With it, `rdata` carries the byte the memory presented on the last cycle of the read phase.
- R4: A write holds `mem_we_n` low for exactly WP = ceil(max(8, 10, 7 ns)/period) cycles (1 at 10 ns), with `mem_ce_n`=0 and `mem_oe_n`=1 throughout.
- R5: `mem_addr` and `mem_dq_out` do not change while `mem_we_n` is low.
- R6: `mem_dq_oe` is 1 only while `mem_ce_n`=0 and `mem_oe_n`=1, during a write.
- R7: After a read, a guard of TA = ceil(7 ns/period) cycles (minimum 1) passes before a new request can be accepted. The drive enable therefore rises no sooner than TA+1 cycles after `mem_oe_n` returns high.
- R8: `ready` falls in the cycle after a request is accepted. It stays low for RD+TA cycles after a read and for WP+WH cycles after a write. A request raised while `ready` is low is ignored.
- R9: A write keeps `mem_ce_n` low for WP+WH cycles, where WH = max(1, ceil(12 ns/period) − WP), so the whole write lasts at least the 12 ns cycle minimum (2 cycles at 10 ns).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request, taken when `ready` is 1 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Host byte address |
| req_wdata | input | 8 | Host write byte |
| ready | output | 1 | Controller idle and able to accept |
| rdata | output | 8 | Read byte, valid with `rvalid` |
| rvalid | output | 1 | One-cycle read completion strobe |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq_out | output | 8 | Byte driven toward the memory |
| mem_dq_in | input | 8 | Byte received from the memory |
| mem_dq_oe | output | 1 | Pad drive enable for `mem_dq_out` |

## Verification
The bench's memory model returns a junk byte until the output enable has been low for RD whole cycles. A controller that samples early therefore returns wrong data instead of passing by luck. Writes that follow a read straight away probe the bus turnaround: a design without the guard shows a shorter busy time and a drive enable that rises too soon after the output enable returns high. Writes that hit the first and last address, and later reads of them, expose address or data that move while the strobe is low. A request raised while the controller is busy must leave the addressed location unchanged, and must not start a transfer when `ready` returns.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD,
        PH_GUARD,
        PH_WLOW,
        PH_WHIGH
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   ce_n;
        logic   oe_n;
        logic   we_n;
        logic   dq_oe;
    } seq_state_t;

    // Whole cycles covering t_ps at the given period, never below one.
    function automatic int span_cycles(input int t_ps, input int period_ps);
        int c;
        c = (t_ps + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int RD_CYC = 2,
    parameter int TA_CYC = 1,
    parameter int WP_CYC = 1,
    parameter int WH_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_we,
    input  logic             last,
    output logic             ready,
    output logic             accept,
    output logic             capture,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe
);

    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LAST = CNT_W'(TA_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LAST = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] WH_LAST = CNT_W'(WH_CYC - 1);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        accept   = 1'b0;
        capture  = 1'b0;
        load     = 1'b0;
        load_val = '0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    st_d.ce_n = 1'b0;
                    if (req_we) begin
                        st_d.phase = PH_WLOW;
                        st_d.oe_n  = 1'b1;
                        st_d.we_n  = 1'b0;
                        st_d.dq_oe = 1'b1;
                        load_val   = WP_LAST;
                    end else begin
                        st_d.phase = PH_RD;
                        st_d.oe_n  = 1'b0;
                        st_d.we_n  = 1'b1;
                        st_d.dq_oe = 1'b0;
                        load_val   = RD_LAST;
                    end
                end
            end
            PH_RD: begin
                if (last) begin
                    capture    = 1'b1;
                    load       = 1'b1;
                    load_val   = TA_LAST;
                    st_d.phase = PH_GUARD;
                    st_d.ce_n  = 1'b1;
                    st_d.oe_n  = 1'b1;
                end
            end
            PH_GUARD: begin
                if (last) begin
                    st_d.phase = PH_IDLE;
                end
            end
            PH_WLOW: begin
                if (last) begin
                    load       = 1'b1;
                    load_val   = WH_LAST;
                    st_d.phase = PH_WHIGH;
                    st_d.we_n  = 1'b1;
                end
            end
            PH_WHIGH: begin
                if (last) begin
                    st_d.phase = PH_IDLE;
                    st_d.ce_n  = 1'b1;
                    st_d.dq_oe = 1'b0;
                end
            end
            default: begin
                st_d = '{phase: PH_IDLE, ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = (st_q.phase == PH_IDLE);
    assign ce_n  = st_q.ce_n;
    assign oe_n  = st_q.oe_n;
    assign we_n  = st_q.we_n;
    assign dq_oe = st_q.dq_oe;

    AST_WE_HIGH_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> we_n); // R2
    AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (oe_n && !ce_n)); // R4
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (oe_n && !ce_n)); // R6
    AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready); // R8

endmodule

// File: rtl/asram_io_regs.sv
module asram_io_regs #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } io_state_t;

    io_state_t io_d, io_q;

    always_comb begin
        io_d        = io_q;
        io_d.rvalid = capture;
        if (accept) begin
            io_d.addr  = req_addr;
            io_d.wdata = req_wdata;
        end
        if (capture) begin
            io_d.rdata = dq_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_q <= '0;
        end else begin
            io_q <= io_d;
        end
    end

    assign addr   = io_q.addr;
    assign wdata  = io_q.wdata;
    assign rdata  = io_q.rdata;
    assign rvalid = io_q.rvalid;

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(addr) && $stable(wdata))); // R5
    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid); // R3

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_PS = 10000,
    parameter int T_RCYC_PS     = 12000,
    parameter int T_AACC_PS     = 12000,
    parameter int T_OACC_PS     = 6000,
    parameter int T_OREL_PS     = 7000,
    parameter int T_WCYC_PS     = 12000,
    parameter int T_WPUL_PS     = 8000,
    parameter int T_AEND_PS     = 10000,
    parameter int T_DSET_PS     = 7000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    localparam int RD_CYC  = max_of(span_cycles(T_RCYC_PS, CLK_PERIOD_PS),
                             max_of(span_cycles(T_AACC_PS, CLK_PERIOD_PS),
                                    span_cycles(T_OACC_PS, CLK_PERIOD_PS)));
    localparam int TA_CYC  = span_cycles(T_OREL_PS, CLK_PERIOD_PS);
    localparam int WP_CYC  = max_of(span_cycles(T_WPUL_PS, CLK_PERIOD_PS),
                             max_of(span_cycles(T_AEND_PS, CLK_PERIOD_PS),
                                    span_cycles(T_DSET_PS, CLK_PERIOD_PS)));
    localparam int WC_CYC  = span_cycles(T_WCYC_PS, CLK_PERIOD_PS);
    localparam int WH_CYC  = max_of(1, WC_CYC - WP_CYC);
    localparam int MAX_CYC = max_of(max_of(RD_CYC, TA_CYC), max_of(WP_CYC, WH_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int GRD_W   = $clog2(TA_CYC + 2);
    localparam logic [GRD_W-1:0] GRD_SAT = GRD_W'(TA_CYC + 1);

    logic             accept, capture, load, last;
    logic [CNT_W-1:0] load_val;

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .last     (last)
    );

    asram_seq #(
        .CNT_W  (CNT_W),
        .RD_CYC (RD_CYC),
        .TA_CYC (TA_CYC),
        .WP_CYC (WP_CYC),
        .WH_CYC (WH_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_we   (req_we),
        .last     (last),
        .ready    (ready),
        .accept   (accept),
        .capture  (capture),
        .load     (load),
        .load_val (load_val),
        .ce_n     (mem_ce_n),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .dq_oe    (mem_dq_oe)
    );

    asram_io_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .we_n      (mem_we_n),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (mem_dq_in),
        .addr      (mem_addr),
        .wdata     (mem_dq_out),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );

    // Cycles the output enable has been high, saturating; checks the turnaround.
    logic [GRD_W-1:0] grd_d, grd_q;

    always_comb begin
        grd_d = grd_q;
        if (!mem_oe_n) begin
            grd_d = '0;
        end else if (grd_q != GRD_SAT) begin
            grd_d = grd_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grd_q <= GRD_SAT;
        end else begin
            grd_q <= grd_d;
        end
    end

    AST_TURNAROUND_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (grd_q >= GRD_SAT)); // R7

endmodule

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PER_PS     = CLK_PERIOD * 1000;

    function automatic int up_div(input int t_ps);
        int c;
        c = (t_ps + PER_PS - 1) / PER_PS;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int big(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int RD_EXP = big(up_div(12000), up_div(6000));
    localparam int TA_EXP = up_div(7000);
    localparam int WP_EXP = big(up_div(8000), big(up_div(10000), up_div(7000)));
    localparam int WC_EXP = up_div(12000);
    localparam int WH_EXP = big(1, WC_EXP - WP_EXP);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, rvalid;
    logic [7:0]  rdata;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [18:0] mem_addr;
    logic [7:0]  mem_dq_out, mem_dq_in;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asram_ctrl u_asram_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .ready      (ready),
        .rdata      (rdata),
        .rvalid     (rvalid),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_in  (mem_dq_in),
        .mem_dq_oe  (mem_dq_oe)
    );

    // Memory model and host-side reference.
    logic [7:0] mem_arr [int];
    logic [7:0] ref_arr [int];
    int         oe_age = 0;

    function automatic logic [7:0] blank_val(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'd0, a[18:16]};
    endfunction

    function automatic logic [7:0] mem_peek(input logic [18:0] a);
        return mem_arr.exists(int'(a)) ? mem_arr[int'(a)] : blank_val(a);
    endfunction

    function automatic logic [7:0] ref_peek(input logic [18:0] a);
        return ref_arr.exists(int'(a)) ? ref_arr[int'(a)] : blank_val(a);
    endfunction

    assign mem_dq_in = (oe_age >= RD_EXP) ? mem_peek(mem_addr) : 8'hEE;

    always @(negedge clk) begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n) oe_age <= oe_age + 1;
        else oe_age <= 0;
    end

    always @(posedge mem_we_n) begin
        if (mem_ce_n === 1'b0) mem_arr[int'(mem_addr)] = mem_dq_oe ? mem_dq_out : 8'h5A;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Port monitor, sampled between clock edges.
    int          oe_run = 0, we_run = 0, ce_run = 0, since_oe = 1000;
    bit          wr_seen = 0, prev_oe = 0;
    logic [18:0] a_lock;
    logic [7:0]  d_lock;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mem_oe_n) since_oe = (since_oe < 1000) ? since_oe + 1 : since_oe;
            else since_oe = 0;
            if (!mem_oe_n) begin
                chk(mem_we_n, "R2 strobe high in read", int'(mem_we_n), 1);
                oe_run++;
            end else if (oe_run > 0) begin
                chk(oe_run == RD_EXP, "R2 read phase length", oe_run, RD_EXP);
                oe_run = 0;
            end
            if (!mem_we_n) begin
                if (we_run == 0) begin
                    a_lock = mem_addr;
                    d_lock = mem_dq_out;
                end else begin
                    chk(mem_addr == a_lock && mem_dq_out == d_lock, "R5 hold under strobe",
                        int'(mem_addr), int'(a_lock));
                end
                chk(mem_oe_n && !mem_ce_n, "R4 oe high ce low in write", int'(mem_oe_n), 1);
                we_run++;
            end else if (we_run > 0) begin
                chk(we_run == WP_EXP, "R4 strobe width", we_run, WP_EXP);
                we_run = 0;
            end
            if (!mem_ce_n) begin
                ce_run++;
                if (!mem_we_n) wr_seen = 1;
            end else if (ce_run > 0) begin
                if (wr_seen) chk(ce_run == WP_EXP + WH_EXP, "R9 write cycle length", ce_run, WP_EXP + WH_EXP);
                else chk(ce_run == RD_EXP, "R2 read select length", ce_run, RD_EXP);
                ce_run = 0;
                wr_seen = 0;
            end
            if (mem_dq_oe) begin
                chk(mem_oe_n && !mem_ce_n, "R6 drive only in write", int'(mem_oe_n), 1);
                if (!prev_oe) chk(since_oe >= TA_EXP + 1, "R7 turnaround", since_oe, TA_EXP + 1);
            end
            prev_oe = mem_dq_oe;
        end
    end

    task automatic do_write(input logic [18:0] a, input logic [7:0] d);
        int busy;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        busy = 0;
        while (!ready) begin
            busy++;
            @(negedge clk);
        end
        ref_arr[int'(a)] = d;
        chk(busy == WP_EXP + WH_EXP, "R8 write busy", busy, WP_EXP + WH_EXP);
    endtask

    task automatic do_read(input logic [18:0] a, input bit poke, input logic [18:0] pa);
        int         busy, nval;
        logic [7:0] got;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; req_we = 1'b0; req_addr = a;
        @(negedge clk);
        req = 1'b0;
        busy = 0; nval = 0; got = '0;
        while (1) begin
            if (rvalid) begin
                nval++;
                got = rdata;
            end
            if (ready) break;
            if (poke && busy == 1) begin
                req = 1'b1; req_we = 1'b1; req_addr = pa; req_wdata = ~ref_peek(pa);
            end else begin
                req = 1'b0;
            end
            busy++;
            @(negedge clk);
        end
        chk(nval == 1, "R3 single rvalid", nval, 1);
        chk(got == ref_peek(a), "R3 read data", int'(got), int'(ref_peek(a)));
        chk(busy == RD_EXP + TA_EXP, "R8 read busy", busy, RD_EXP + TA_EXP);
        if (poke) begin
            @(negedge clk);
            chk(mem_ce_n && ready, "R8 busy request ignored", int'(mem_ce_n), 1);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(posedge clk);
        #1;
        chk(ready && !rvalid && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe,
            "R1 state in reset", int'({ready, rvalid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}), 'h2E);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready && !rvalid && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe,
            "R1 state after reset", int'({ready, rvalid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}), 'h2E);

        // Directed corners: extreme addresses, blank reads, read then write.
        do_read(19'h00000, 0, '0);
        do_write(19'h00000, 8'hA5);
        do_write(19'h7FFFF, 8'h3C);
        do_read(19'h7FFFF, 0, '0);
        do_write(19'h00001, 8'hFF);
        do_read(19'h00000, 0, '0);
        do_read(19'h00001, 0, '0);
        do_write(19'h00002, 8'h00);
        do_read(19'h00002, 0, '0);
        // Request raised while busy must not reach the memory (R8).
        do_read(19'h00000, 1, 19'h00003);
        do_read(19'h00003, 0, '0);

        for (int i = 0; i < 400; i++) begin
            logic [18:0] a;
            logic [31:0] r;
            r = $urandom;
            a = (r[3:2] == 2'b00) ? {r[31:16], 3'b0} : {15'h7FF0, r[7:4]};
            if (r[0]) do_write(a, r[15:8]);
            else do_read(a, r[1] & r[8], {15'h7FF0, r[12:9]});
        end

        repeat (4) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule